// File: doc/BRIEF.md
# BCD Calendar Real-Time Clock

This block is a real-time clock that software reaches through a 32-bit register port. It keeps seconds, minutes, hours, day of month, month, a two-digit year (00 to 99 for 2000 to 2099) and a day-of-week count. All of these advance on a one-cycle tick pulse that arrives once per second. Every time and date field is a packed BCD byte. The counters stay frozen until software writes a 32-bit unlock key to the init register. After that, each tick advances the clock through minute, hour, day, month and year boundaries. Month lengths and leap years are handled.

Software can set and read the time, the date and the weekday. It can also program an alarm time and date, enable two interrupt sources and clear their flags by writing 1. The alarm flag is raised when the clock reaches the alarm moment. The update flag is raised on every second. A level interrupt output is high while any enabled flag is set.

Reads are combinational from the registered state. All counters change on the same clock edge, so a read never mixes fields from before and after a tick.

Top module: `bcd_rtc`

## Requirements
- R1: After reset: time reads 0x000000, calendar 0x000101, weekday 6, clock format 1, leap-year 1, and init, interrupt enable and interrupt status 0. The interrupt output is low.
- R2: Writing 0xA5EB1357 to offset 0x00 sets bit 0 (active), which stays set until reset. Any other value written there has no effect. While bit 0 is clear, ticks change no counter.
- R3: Time register at 0x0C holds BCD seconds in bits 7:0, minutes in bits 15:8 and hours in bits 23:16. On an active tick, seconds count 00 to 59 and wrap, carrying into minutes (00 to 59), which carry into hours (00 to 23).
- R4: Calendar register at 0x10 holds BCD day in bits 7:0, month (01 to 12) in bits 15:8 and year in bits 23:16. An hour wrap advances the day. The day wraps to 01 after 31, 30 or 28 according to the month, and after 29 in February of a year divisible by 4. Month 12 wraps to 01 and carries into the year, and year 99 wraps to 00.
- R5: Weekday register at 0x18 holds a binary 0..6 in bits 2:0, with 0 meaning Sunday. It advances modulo 7 on each day wrap and on no other tick.
- R6: A write to the time, calendar or weekday register appears on the next cycle with exactly the written value. In a cycle with such a write, the tick advances none of the counters.
- R7: Time alarm (0x1C) and calendar alarm (0x20) use the time and calendar layouts. Status bit 0 is set on an active tick when bits 23:0 of the time and calendar values after that tick equal the alarm registers.
- R8: Status bit 1 (update flag) is set on every active tick.
- R9: Interrupt status at 0x2C: writing 1 to a bit clears it and writing 0 leaves it unchanged. If a flag is set and cleared in the same cycle, it ends up set.
- R10: Interrupt enable at 0x28: bit 0 is the alarm enable and bit 1 the update enable. The interrupt output is high exactly when some status bit and its enable bit are both 1.
- R11: Leap-year register at 0x24 reads 1 in bit 0 when the current year is divisible by 4. Clock-format register at 0x14 has bit 0 read/write, resetting to 1. Unmapped offsets and unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse once per second |
| addr | input | 6 | Byte offset of the register accessed |
| wr_en | input | 1 | Write strobe for wdata at addr |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| irq | output | 1 | Level interrupt request |

## Verification
Two pairs of actions can land in the same cycle. The first is a tick together with a software write-one-to-clear of the update flag. The bench drives both strobes at the same edge and expects the flag to read back set. The second is a tick together with a time write. Here the bench expects the written value and no increment on top of it. Around these collisions, the bench sweeps every second of an hour and the last day of every month over four consecutive years, and it computes each expected date arithmetically.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int FIELD_W = 8;
  localparam int TIME_W  = 3 * FIELD_W;
  localparam int WDAY_W  = 3;
  localparam int IRQ_N   = 2;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) bcd_inc = {v[7:4] + 4'd1, 4'd0};
    else                bcd_inc = {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [6:0] bcd_to_bin(input logic [7:0] v);
    bcd_to_bin = {3'd0, v[7:4]} * 7'd10 + {3'd0, v[3:0]};
  endfunction

  function automatic logic year_is_leap(input logic [7:0] yr);
    logic [6:0] b;
    b = bcd_to_bin(yr);
    year_is_leap = (b[1:0] == 2'd0);
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'h02:                      month_len = year_is_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: month_len = 8'h30;
      default:                    month_len = 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_adv,
  input  logic              time_wr,
  input  logic              cal_wr,
  input  logic              wday_wr,
  input  logic [31:0]       wdata,
  output logic [TIME_W-1:0] time_q,
  output logic [TIME_W-1:0] cal_q,
  output logic [WDAY_W-1:0] wday_q,
  output logic [TIME_W-1:0] time_n,
  output logic [TIME_W-1:0] cal_n,
  output logic              day_roll
);
  logic [TIME_W-1:0] time_inc, cal_inc;
  logic [WDAY_W-1:0] wday_n;
  logic s_wrap, m_wrap, h_wrap, last_day, year_end, step;

  assign step = tick_adv & ~(time_wr | cal_wr | wday_wr);

  always_comb begin
    s_wrap   = time_q[7:0] == 8'h59;
    m_wrap   = time_q[15:8] == 8'h59;
    h_wrap   = time_q[23:16] == 8'h23;
    day_roll = s_wrap & m_wrap & h_wrap;
    last_day = cal_q[7:0] >= month_len(cal_q[15:8], cal_q[23:16]);
    year_end = cal_q[15:8] == 8'h12;

    time_inc[7:0]   = s_wrap ? 8'h00 : bcd_inc(time_q[7:0]);
    time_inc[15:8]  = !s_wrap ? time_q[15:8] : (m_wrap ? 8'h00 : bcd_inc(time_q[15:8]));
    time_inc[23:16] = !(s_wrap & m_wrap) ? time_q[23:16] :
                      (h_wrap ? 8'h00 : bcd_inc(time_q[23:16]));

    cal_inc = cal_q;
    if (day_roll) begin
      cal_inc[7:0] = last_day ? 8'h01 : bcd_inc(cal_q[7:0]);
      if (last_day) begin
        cal_inc[15:8] = year_end ? 8'h01 : bcd_inc(cal_q[15:8]);
        if (year_end)
          cal_inc[23:16] = (cal_q[23:16] == 8'h99) ? 8'h00 : bcd_inc(cal_q[23:16]);
      end
    end

    time_n = time_wr ? wdata[TIME_W-1:0] : (step ? time_inc : time_q);
    cal_n  = cal_wr  ? wdata[TIME_W-1:0] : (step ? cal_inc  : cal_q);
    if (wday_wr)                wday_n = wdata[WDAY_W-1:0];
    else if (step && day_roll)  wday_n = (wday_q >= 3'd6) ? 3'd0 : wday_q + 3'd1;
    else                        wday_n = wday_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      time_q <= '0;
      cal_q  <= 24'h000101;
      wday_q <= 3'd6;
    end else begin
      time_q <= time_n;
      cal_q  <= cal_n;
      wday_q <= wday_n;
    end
  end
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_adv,
  input  logic              talm_wr,
  input  logic              calm_wr,
  input  logic              en_wr,
  input  logic              sts_wr,
  input  logic [31:0]       wdata,
  input  logic [TIME_W-1:0] time_n,
  input  logic [TIME_W-1:0] cal_n,
  output logic [TIME_W-1:0] talm_q,
  output logic [TIME_W-1:0] calm_q,
  output logic [IRQ_N-1:0]  en_q,
  output logic [IRQ_N-1:0]  sts_q,
  output logic              alarm_hit,
  output logic              irq
);
  logic [IRQ_N-1:0] set_v;

  assign alarm_hit = tick_adv && (time_n == talm_q) && (cal_n == calm_q);
  assign set_v     = {tick_adv, alarm_hit};
  assign irq       = |(sts_q & en_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      talm_q <= '0;
      calm_q <= '0;
      en_q   <= '0;
      sts_q  <= '0;
    end else begin
      if (talm_wr) talm_q <= wdata[TIME_W-1:0];
      if (calm_wr) calm_q <= wdata[TIME_W-1:0];
      if (en_wr)   en_q   <= wdata[IRQ_N-1:0];
      for (int i = 0; i < IRQ_N; i++) begin
        if (set_v[i])                     sts_q[i] <= 1'b1;
        else if (sts_wr && wdata[i])      sts_q[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bcd_rtc.sv
module bcd_rtc
  import rtc_pkg::*;
#(
  parameter int          ADDR_W     = 6,
  parameter logic [31:0] UNLOCK_KEY = 32'hA5EB1357
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_INIT = ADDR_W'(6'h00);
  localparam logic [ADDR_W-1:0] A_TIME = ADDR_W'(6'h0C);
  localparam logic [ADDR_W-1:0] A_CAL  = ADDR_W'(6'h10);
  localparam logic [ADDR_W-1:0] A_FMT  = ADDR_W'(6'h14);
  localparam logic [ADDR_W-1:0] A_WDAY = ADDR_W'(6'h18);
  localparam logic [ADDR_W-1:0] A_TALM = ADDR_W'(6'h1C);
  localparam logic [ADDR_W-1:0] A_CALM = ADDR_W'(6'h20);
  localparam logic [ADDR_W-1:0] A_LEAP = ADDR_W'(6'h24);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(6'h28);
  localparam logic [ADDR_W-1:0] A_ISTS = ADDR_W'(6'h2C);

  logic active_q, fmt24_q, tick_adv, any_wr, day_roll, alarm_hit;
  logic time_wr, cal_wr, wday_wr, talm_wr, calm_wr, en_wr, sts_wr;
  logic [TIME_W-1:0] time_q, cal_q, time_n, cal_n, talm_q, calm_q;
  logic [WDAY_W-1:0] wday_q;
  logic [IRQ_N-1:0]  en_q, sts_q;

  assign tick_adv = tick & active_q;
  assign time_wr  = wr_en && addr == A_TIME;
  assign cal_wr   = wr_en && addr == A_CAL;
  assign wday_wr  = wr_en && addr == A_WDAY;
  assign talm_wr  = wr_en && addr == A_TALM;
  assign calm_wr  = wr_en && addr == A_CALM;
  assign en_wr    = wr_en && addr == A_IEN;
  assign sts_wr   = wr_en && addr == A_ISTS;
  assign any_wr   = time_wr | cal_wr | wday_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      fmt24_q  <= 1'b1;
    end else begin
      if (wr_en && addr == A_INIT && wdata == UNLOCK_KEY) active_q <= 1'b1;
      if (wr_en && addr == A_FMT) fmt24_q <= wdata[0];
    end
  end

  rtc_timekeeper tk_i (
    .clk(clk), .rst_n(rst_n), .tick_adv(tick_adv),
    .time_wr(time_wr), .cal_wr(cal_wr), .wday_wr(wday_wr), .wdata(wdata),
    .time_q(time_q), .cal_q(cal_q), .wday_q(wday_q),
    .time_n(time_n), .cal_n(cal_n), .day_roll(day_roll)
  );

  rtc_irq_ctrl ic_i (
    .clk(clk), .rst_n(rst_n), .tick_adv(tick_adv),
    .talm_wr(talm_wr), .calm_wr(calm_wr), .en_wr(en_wr), .sts_wr(sts_wr),
    .wdata(wdata), .time_n(time_n), .cal_n(cal_n),
    .talm_q(talm_q), .calm_q(calm_q), .en_q(en_q), .sts_q(sts_q),
    .alarm_hit(alarm_hit), .irq(irq)
  );

  always_comb begin
    rdata = '0;
    case (addr)
      A_INIT: rdata[0] = active_q;
      A_TIME: rdata[TIME_W-1:0] = time_q;
      A_CAL:  rdata[TIME_W-1:0] = cal_q;
      A_FMT:  rdata[0] = fmt24_q;
      A_WDAY: rdata[WDAY_W-1:0] = wday_q;
      A_TALM: rdata[TIME_W-1:0] = talm_q;
      A_CALM: rdata[TIME_W-1:0] = calm_q;
      A_LEAP: rdata[0] = year_is_leap(cal_q[23:16]);
      A_IEN:  rdata[IRQ_N-1:0] = en_q;
      A_ISTS: rdata[IRQ_N-1:0] = sts_q;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/bcd_rtc_chk.sv
module bcd_rtc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick_adv,
  input logic        active,
  input logic        any_wr,
  input logic        sts_wr,
  input logic        alarm_hit,
  input logic [31:0] wdata,
  input logic [23:0] time_q,
  input logic [23:0] cal_q,
  input logic [1:0]  sts_q,
  input logic        irq
);
  // R2: once unlocked, the clock stays active
  p_active_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> active);
  // R2: a frozen clock changes only through software writes
  p_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !any_wr) |=> $stable(time_q) && $stable(cal_q));
  // R8: every active tick leaves the update flag set
  p_update_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tick_adv |=> sts_q[1]);
  // R7: an alarm match leaves the alarm flag set
  p_alarm_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_hit |=> sts_q[0]);
  // R9: write-one clears the update flag when no tick competes
  p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_wr && wdata[1] && !tick_adv) |=> !sts_q[1]);
  // R10: interrupt only with a pending flag
  p_irq_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (sts_q != 2'b00));
  // R3: a pure tick step keeps seconds a valid BCD value
  p_sec_bcd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_adv && !any_wr && time_q[7:0] <= 8'h59 && time_q[3:0] <= 4'h9)
      |=> (time_q[7:0] <= 8'h59 && time_q[3:0] <= 4'h9));
  // R4: a pure tick step never produces day 00
  p_day_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_adv && !any_wr && cal_q[7:0] != 8'h00) |=> cal_q[7:0] != 8'h00);
endmodule

bind bcd_rtc bcd_rtc_chk chk_i (
  .clk(clk), .rst_n(rst_n), .tick_adv(tick_adv), .active(active_q),
  .any_wr(any_wr), .sts_wr(sts_wr), .alarm_hit(alarm_hit), .wdata(wdata),
  .time_q(time_q), .cal_q(cal_q), .sts_q(sts_q), .irq(irq)
);

// File: tb/bcd_rtc_tb_top.sv
`timescale 1ns/1ps
module bcd_rtc_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        irq;
  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  bcd_rtc dut_i (.clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr),
                 .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .irq(irq));

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [7:0] to_bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int mdays(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic pulse;
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
  endtask

  task automatic tick_wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); tick = 1; wr_en = 1; addr = a; wdata = d;
    @(negedge clk); tick = 0; wr_en = 0;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    rd(6'h0C, v); chk("R1 time", v, 32'h0);
    rd(6'h10, v); chk("R1 cal", v, 32'h000101);
    rd(6'h18, v); chk("R1 wday", v, 32'd6);
    rd(6'h14, v); chk("R1 fmt", v, 32'd1);
    rd(6'h24, v); chk("R1 leap", v, 32'd1);
    rd(6'h00, v); chk("R1 init", v, 32'd0);
    rd(6'h2C, v); chk("R1 sts", v, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    // R2 frozen until unlock
    pulse; rd(6'h0C, v); chk("R2 frozen", v, 32'h0);
    rd(6'h2C, v); chk("R2 no flag", v, 32'h0);
    wr(6'h00, 32'hA5EB1356); rd(6'h00, v); chk("R2 bad key", v, 32'd0);
    pulse; rd(6'h0C, v); chk("R2 still frozen", v, 32'h0);
    wr(6'h00, 32'hA5EB1357); rd(6'h00, v); chk("R2 unlocked", v, 32'd1);
    // R3 sweep every second of one hour
    wr(6'h0C, 32'h000000);
    for (int s = 1; s <= 3600; s++) begin
      pulse; rd(6'h0C, v);
      chk("R3 sweep", v, {8'h0, 8'h01 & {8{s == 3600}}, to_bcd((s / 60) % 60), to_bcd(s % 60)});
    end
    // R3/R4/R5 midnight rolls day and weekday
    wr(6'h10, 32'h000115); wr(6'h18, 32'd6); wr(6'h0C, 32'h235959);
    pulse; rd(6'h0C, v); chk("R3 hour wrap", v, 32'h0);
    rd(6'h10, v); chk("R4 day inc", v, 32'h000116);
    rd(6'h18, v); chk("R5 wday wrap", v, 32'd0);
    pulse; rd(6'h18, v); chk("R5 no roll", v, 32'd0);
    // R4 last and next-to-last day of every month, years 00..03
    for (int y = 0; y < 4; y++) begin
      for (int m = 1; m <= 12; m++) begin
        int d;
        d = mdays(m, y);
        wr(6'h10, {8'h0, to_bcd(y), to_bcd(m), to_bcd(d - 1)});
        wr(6'h0C, 32'h235959); pulse; rd(6'h10, v);
        chk("R4 mid", v, {8'h0, to_bcd(y), to_bcd(m), to_bcd(d)});
        wr(6'h0C, 32'h235959); pulse; rd(6'h10, v);
        chk("R4 end", v, {8'h0, to_bcd(m == 12 ? y + 1 : y), to_bcd(m == 12 ? 1 : m + 1), 8'h01});
      end
    end
    wr(6'h10, 32'h991231); wr(6'h0C, 32'h235959); pulse;
    rd(6'h10, v); chk("R4 century", v, 32'h000101);
    // R11 leap register and format bit
    wr(6'h10, 32'h040101); rd(6'h24, v); chk("R11 leap04", v, 32'd1);
    wr(6'h10, 32'h050101); rd(6'h24, v); chk("R11 leap05", v, 32'd0);
    wr(6'h14, 32'd0); rd(6'h14, v); chk("R11 fmt rw", v, 32'd0);
    rd(6'h30, v); chk("R11 unmapped", v, 32'd0);
    // R6 write collides with tick
    wr(6'h0C, 32'h101010);
    tick_wr(6'h0C, 32'h123456); rd(6'h0C, v); chk("R6 write wins", v, 32'h123456);
    tick_wr(6'h18, 32'd2); rd(6'h0C, v); chk("R6 no inc", v, 32'h123456);
    rd(6'h18, v); chk("R6 wday", v, 32'd2);
    // R7 alarm
    wr(6'h2C, 32'h3); wr(6'h28, 32'h1);
    wr(6'h10, 32'h150305); wr(6'h0C, 32'h101010);
    wr(6'h1C, 32'h101011); wr(6'h20, 32'h150305);
    rd(6'h2C, v); chk("R7 idle", v & 32'h1, 32'h0);
    pulse; rd(6'h2C, v); chk("R7 match", v & 32'h1, 32'h1);
    chk("R10 alarm irq", {31'd0, irq}, 32'd1);
    wr(6'h2C, 32'h0); rd(6'h2C, v); chk("R9 write 0", v & 32'h1, 32'h1);
    wr(6'h2C, 32'h1); rd(6'h2C, v); chk("R9 clear", v & 32'h1, 32'h0);
    chk("R10 irq low", {31'd0, irq}, 32'd0);
    wr(6'h20, 32'h150306); wr(6'h0C, 32'h101010);
    pulse; rd(6'h2C, v); chk("R7 date mismatch", v & 32'h1, 32'h0);
    // R8 update flag and R10 enable
    wr(6'h2C, 32'h3); wr(6'h28, 32'h0);
    pulse; rd(6'h2C, v); chk("R8 update", v, 32'h2);
    chk("R10 masked", {31'd0, irq}, 32'd0);
    wr(6'h28, 32'h2); #1 chk("R10 update irq", {31'd0, irq}, 32'd1);
    // R9 set and clear in the same cycle
    tick_wr(6'h2C, 32'h2); rd(6'h2C, v); chk("R9 set wins", v & 32'h2, 32'h2);
    wr(6'h2C, 32'h2); rd(6'h2C, v); chk("R9 clear upd", v & 32'h2, 32'h0);
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule